// File: doc/BRIEF.md
# Address/GPIO Port Controller

This block holds the control logic for a small bidirectional port of `WIDTH` pins (four by default). Depending on the operating mode and a per-pin direction bit, each pin carries one bit of the internal address bus outward, works as a general-purpose output driven from a data latch, or stays an input. When a pin is an input, a per-pin pull-up may be enabled. A per-pin open-drain option turns any driven high level into a released line.

Software reaches five byte-wide registers over a plain strobe bus with a 16-bit address:

| Register | Address | Access |
|---|---|---|
| Direction | 0xFEB9 | write-only |
| Data latch | 0xFF69 | read/write |
| Pin sample | 0xFF59 | read-only |
| Pull-up | 0xFF70 | read/write |
| Open-drain | 0xFF77 | read/write |

Two standby inputs change pin behaviour:
- **Hardware standby** clears the direction bits.
- **Software standby** leaves them untouched. During software standby, a flag selects whether the address pins freeze at their last value or float.

The pad drivers themselves sit outside this block.

Top module: `addr_gpio_port`

## Requirements
- R1: After reset, the direction, data, pull-up and open-drain registers are all zero. `pin_oe` and `pin_pu` are zero in every mode except 4 and 5, and a read of any register but the direction and pin-sample registers returns 0x00.
- R2: A write strobe at 0xFF69 (data), 0xFF70 (pull-up) or 0xFF77 (open-drain) loads `bus_wdata[WIDTH-1:0]` into that register. A later read returns the stored bits in `bus_rdata[WIDTH-1:0]` with all higher bits zero. The read data appears on the clock edge that samples the read strobe.
- R3: A read of the direction register (0xFEB9) always returns the fixed pattern `DIR_RD_VAL` (default 0xFF) and never the stored bits. Writes there keep only bits `WIDTH-1:0`, and the bits above have no effect.
- R4: A read at 0xFF59 returns the `pin_in` levels present at the sampling edge in bits `WIDTH-1:0`. A write to 0xFF59 changes no register.
- R5: In modes 4 and 5 (`op_mode` = 3'd4 or 3'd5), every pin is an address output driving `int_addr[i]`, whatever the direction bits hold.
- R6: In mode 6, a pin whose direction bit is 1 drives `int_addr[i]`. A pin whose direction bit is 0 is an input with `pin_oe[i]` = 0.
- R7: In every other mode, a pin whose direction bit is 1 drives its data-latch bit. A pin whose direction bit is 0 is an input.
- R8: `pin_pu[i]` is 1 exactly when pin i is an input and its pull-up bit is 1. It is never 1 for a pin acting as an output.
- R9: When a pin's open-drain bit is 1, the pin drives only a low level. When the value to drive is 1, `pin_oe[i]` is 0. `pin_out` is 0 whenever `pin_oe` is 0.
- R10: While `sw_standby` is 1 and `standby_oe` is 1, address pins keep the `int_addr` value sampled at the last clock edge before standby began. While `sw_standby` is 1 and `standby_oe` is 0, address pins have `pin_oe` = 0. Pins driving the data latch are unaffected by either case.
- R11: `hw_standby` high at a clock edge clears the direction bits, and this takes priority over a simultaneous write. Software standby leaves the direction bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| op_mode | input | 3 | Operating mode selector |
| int_addr | input | WIDTH | Internal address bits for the port |
| pin_in | input | WIDTH | Sampled pin levels |
| sw_standby | input | 1 | Software standby state |
| hw_standby | input | 1 | Hardware standby state |
| standby_oe | input | 1 | Keep address outputs driven in software standby |
| pin_oe | output | WIDTH | Per-pin output enable |
| pin_out | output | WIDTH | Per-pin output value |
| pin_pu | output | WIDTH | Per-pin pull-up enable |

## Verification
Results arrive at three different latencies:
- **Pin outputs** are combinational in the current mode, standby inputs and `int_addr`. The bench drives inputs at a falling edge and samples the outputs 1 ns later in the same cycle.
- **Register writes** take effect at the next rising edge. Their effect on the pins is checked from the following falling edge on.
- **Read data** is registered on the edge that samples the strobe. It is compared one full cycle after the strobe was driven.

The address held during software standby is the value sampled at the last rising edge with standby low. The bench's reference model captures it at that same edge.

// File: rtl/agp_pkg.sv
package agp_pkg;

   localparam logic [15:0] OFS_DIR = 16'hFEB9;
   localparam logic [15:0] OFS_DAT = 16'hFF69;
   localparam logic [15:0] OFS_PIN = 16'hFF59;
   localparam logic [15:0] OFS_PUL = 16'hFF70;
   localparam logic [15:0] OFS_ODC = 16'hFF77;

   localparam logic [2:0] MODE_ADDR_A = 3'd4;
   localparam logic [2:0] MODE_ADDR_B = 3'd5;
   localparam logic [2:0] MODE_MIXED  = 3'd6;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_DIR,
      SEL_DAT,
      SEL_PIN,
      SEL_PUL,
      SEL_ODC
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [15:0] ofs);
      reg_sel_e s;
      unique case (ofs)
         OFS_DIR: s = SEL_DIR;
         OFS_DAT: s = SEL_DAT;
         OFS_PIN: s = SEL_PIN;
         OFS_PUL: s = SEL_PUL;
         OFS_ODC: s = SEL_ODC;
         default: s = SEL_NONE;
      endcase
      return s;
   endfunction

   function automatic logic mode_forced(input logic [2:0] m);
      return (m == MODE_ADDR_A) || (m == MODE_ADDR_B);
   endfunction

endpackage

// File: rtl/agp_regs.sv
module agp_regs
   import agp_pkg::*;
#(
   parameter int         WIDTH      = 4,
   parameter logic [7:0] DIR_RD_VAL = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_stby,
   input  logic [15:0]      bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [7:0]       bus_wdata,
   input  logic [WIDTH-1:0] pin_in,
   output logic [7:0]       bus_rdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] dat_q,
   output logic [WIDTH-1:0] pul_q,
   output logic [WIDTH-1:0] odc_q
);

   reg_sel_e         sel;
   logic [7:0]       rd_next;
   logic [WIDTH-1:0] wr_bits;
   logic             unused_wdata;

   assign sel          = decode_ofs(bus_addr);
   assign wr_bits      = bus_wdata[WIDTH-1:0];
   assign unused_wdata = ^bus_wdata;

   // Direction: hardware standby clear wins over a write in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '0;
      end else if (hw_stby) begin
         dir_q <= '0;
      end else if (bus_wr && sel == SEL_DIR) begin
         dir_q <= wr_bits;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dat_q <= '0;
         pul_q <= '0;
         odc_q <= '0;
      end else if (bus_wr) begin
         if (sel == SEL_DAT) dat_q <= wr_bits;
         if (sel == SEL_PUL) pul_q <= wr_bits;
         if (sel == SEL_ODC) odc_q <= wr_bits;
      end
   end

   always_comb begin
      rd_next = 8'h00;
      unique case (sel)
         SEL_DIR: rd_next = DIR_RD_VAL;
         SEL_DAT: rd_next[WIDTH-1:0] = dat_q;
         SEL_PIN: rd_next[WIDTH-1:0] = pin_in;
         SEL_PUL: rd_next[WIDTH-1:0] = pul_q;
         SEL_ODC: rd_next[WIDTH-1:0] = odc_q;
         default: rd_next = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= 8'h00;
      end else if (bus_rd) begin
         bus_rdata <= rd_next;
      end
   end

endmodule

// File: rtl/agp_role.sv
module agp_role
   import agp_pkg::*;
#(
   parameter int WIDTH = 4
) (
   input  logic [2:0]       op_mode,
   input  logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] addr_fn,
   output logic [WIDTH-1:0] gpio_fn
);

   logic forced;
   logic mixed;

   assign forced = mode_forced(op_mode);
   assign mixed  = (op_mode == MODE_MIXED);

   for (genvar i = 0; i < WIDTH; i++) begin : g_role
      assign addr_fn[i] = forced | (mixed & dir_q[i]);
      assign gpio_fn[i] = ~forced & ~mixed & dir_q[i];
   end

endmodule

// File: rtl/agp_addr_hold.sv
module agp_addr_hold #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_stby,
   input  logic             stby_oe,
   input  logic [WIDTH-1:0] int_addr,
   output logic [WIDTH-1:0] addr_val,
   output logic             addr_ok
);

   logic [WIDTH-1:0] held_q;

   // Tracks the address bus until standby begins, then freezes.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q <= '0;
      end else if (!sw_stby) begin
         held_q <= int_addr;
      end
   end

   assign addr_val = sw_stby ? held_q : int_addr;
   assign addr_ok  = ~sw_stby | stby_oe;

endmodule

// File: rtl/agp_pin_drv.sv
module agp_pin_drv (
   input  logic addr_fn,
   input  logic gpio_fn,
   input  logic addr_bit,
   input  logic addr_ok,
   input  logic dat,
   input  logic pul,
   input  logic odc,
   output logic oe,
   output logic out,
   output logic pu
);

   logic val;
   logic drive;

   assign val   = addr_fn ? addr_bit : dat;
   assign drive = gpio_fn | (addr_fn & addr_ok);
   assign oe    = drive & ~(odc & val);
   assign out   = drive & val & ~odc;
   assign pu    = pul & ~addr_fn & ~gpio_fn;

endmodule

// File: rtl/addr_gpio_port.sv
module addr_gpio_port #(
   parameter int         WIDTH      = 4,
   parameter logic [7:0] DIR_RD_VAL = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [15:0]      bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic [2:0]       op_mode,
   input  logic [WIDTH-1:0] int_addr,
   input  logic [WIDTH-1:0] pin_in,
   input  logic             sw_standby,
   input  logic             hw_standby,
   input  logic             standby_oe,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_pu
);

   if (WIDTH < 1 || WIDTH > 8) begin : g_bad_width
      $error("addr_gpio_port: WIDTH must lie in 1..8");
   end

   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] dat_q;
   logic [WIDTH-1:0] pul_q;
   logic [WIDTH-1:0] odc_q;
   logic [WIDTH-1:0] addr_fn;
   logic [WIDTH-1:0] gpio_fn;
   logic [WIDTH-1:0] addr_val;
   logic             addr_ok;

   agp_regs #(
      .WIDTH      (WIDTH),
      .DIR_RD_VAL (DIR_RD_VAL)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_stby   (hw_standby),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .pin_in    (pin_in),
      .bus_rdata (bus_rdata),
      .dir_q     (dir_q),
      .dat_q     (dat_q),
      .pul_q     (pul_q),
      .odc_q     (odc_q)
   );

   agp_role #(
      .WIDTH (WIDTH)
   ) u_role (
      .op_mode (op_mode),
      .dir_q   (dir_q),
      .addr_fn (addr_fn),
      .gpio_fn (gpio_fn)
   );

   agp_addr_hold #(
      .WIDTH (WIDTH)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_stby  (sw_standby),
      .stby_oe  (standby_oe),
      .int_addr (int_addr),
      .addr_val (addr_val),
      .addr_ok  (addr_ok)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      agp_pin_drv u_drv (
         .addr_fn  (addr_fn[i]),
         .gpio_fn  (gpio_fn[i]),
         .addr_bit (addr_val[i]),
         .addr_ok  (addr_ok),
         .dat      (dat_q[i]),
         .pul      (pul_q[i]),
         .odc      (odc_q[i]),
         .oe       (pin_oe[i]),
         .out      (pin_out[i]),
         .pu       (pin_pu[i])
      );
   end

endmodule

// File: rtl/agp_chk.sv
module agp_chk
   import agp_pkg::*;
#(
   parameter int         WIDTH      = 4,
   parameter logic [7:0] DIR_RD_VAL = 8'hFF
) (
   input logic             clk,
   input logic             rst_n,
   input logic [15:0]      bus_addr,
   input logic             bus_rd,
   input logic [7:0]       bus_rdata,
   input logic [2:0]       op_mode,
   input logic [WIDTH-1:0] int_addr,
   input logic             sw_standby,
   input logic             standby_oe,
   input logic [WIDTH-1:0] odc_q,
   input logic [WIDTH-1:0] pin_oe,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] pin_pu
);

   logic forced;
   assign forced = mode_forced(op_mode);

   AST_PU_ONLY_ON_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pu & pin_oe) == '0); // R8

   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & pin_out & odc_q) == '0 && (pin_out & ~pin_oe) == '0); // R9

   AST_FORCED_ADDR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (forced && !sw_standby) |->
         (&(pin_oe | (int_addr & odc_q))) && pin_out == (int_addr & ~odc_q)); // R5

   AST_DIR_READ_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == OFS_DIR) |=> bus_rdata == DIR_RD_VAL); // R3

   AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_standby && $past(sw_standby) && standby_oe && $past(standby_oe) &&
       forced && $past(forced) && $stable(odc_q)) |-> $stable(pin_out)); // R10

   AST_STBY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_standby && !standby_oe && forced) |-> pin_oe == '0); // R10

endmodule

bind addr_gpio_port agp_chk #(
   .WIDTH      (WIDTH),
   .DIR_RD_VAL (DIR_RD_VAL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_rd     (bus_rd),
   .bus_rdata  (bus_rdata),
   .op_mode    (op_mode),
   .int_addr   (int_addr),
   .sw_standby (sw_standby),
   .standby_oe (standby_oe),
   .odc_q      (odc_q),
   .pin_oe     (pin_oe),
   .pin_out    (pin_out),
   .pin_pu     (pin_pu)
);

// File: tb/addr_gpio_port_tb.sv
module addr_gpio_port_tb;
   localparam int W = 4;
   localparam logic [15:0] A_DIR = 16'hFEB9;
   localparam logic [15:0] A_DAT = 16'hFF69;
   localparam logic [15:0] A_PIN = 16'hFF59;
   localparam logic [15:0] A_PUL = 16'hFF70;
   localparam logic [15:0] A_ODC = 16'hFF77;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic [15:0]   bus_addr;
   logic          bus_wr, bus_rd;
   logic [7:0]    bus_wdata, bus_rdata;
   logic [2:0]    op_mode;
   logic [W-1:0]  int_addr, pin_in;
   logic          sw_standby, hw_standby, standby_oe;
   logic [W-1:0]  pin_oe, pin_out, pin_pu;

   int n_chk = 0;
   int n_bad = 0;

   addr_gpio_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .op_mode(op_mode), .int_addr(int_addr), .pin_in(pin_in),
      .sw_standby(sw_standby), .hw_standby(hw_standby), .standby_oe(standby_oe),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
   );

   // Reference model of the register state, built from the requirements.
   logic [W-1:0] m_dir, m_dat, m_pul, m_odc, m_held;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_dir <= '0; m_dat <= '0; m_pul <= '0; m_odc <= '0; m_held <= '0;
      end else begin
         if (!sw_standby) m_held <= int_addr;
         if (hw_standby) m_dir <= '0;
         else if (bus_wr && bus_addr == A_DIR) m_dir <= bus_wdata[W-1:0];
         if (bus_wr && bus_addr == A_DAT) m_dat <= bus_wdata[W-1:0];
         if (bus_wr && bus_addr == A_PUL) m_pul <= bus_wdata[W-1:0];
         if (bus_wr && bus_addr == A_ODC) m_odc <= bus_wdata[W-1:0];
      end
   end

   function automatic void exp_pins(output logic [W-1:0] eoe, output logic [W-1:0] eout,
                                    output logic [W-1:0] epu);
      bit frc, mix;
      frc = (op_mode == 3'd4) || (op_mode == 3'd5);
      mix = (op_mode == 3'd6);
      for (int i = 0; i < W; i++) begin
         bit is_addr, is_gpio, v, drv;
         is_addr = frc || (mix && m_dir[i]);
         is_gpio = !frc && !mix && m_dir[i];
         v   = is_addr ? (sw_standby ? m_held[i] : int_addr[i]) : m_dat[i];
         drv = is_gpio || (is_addr && (!sw_standby || standby_oe));
         eoe[i]  = drv && !(m_odc[i] && v);
         eout[i] = drv && v && !m_odc[i];
         epu[i]  = m_pul[i] && !is_addr && !is_gpio;
      end
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_pins(input string tag);
      logic [W-1:0] eoe, eout, epu;
      exp_pins(eoe, eout, epu);
      check(tag, "pin_oe", {4'h0, pin_oe}, {4'h0, eoe});
      check(tag, "pin_out", {4'h0, pin_out}, {4'h0, eout});
      check("R8", "pin_pu", {4'h0, pin_pu}, {4'h0, epu});
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
      @(negedge clk);
      bus_rd = 1'b0;
      check(tag, "bus_rdata", bus_rdata, exp);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240607));
      rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
      op_mode = 3'd7; int_addr = '0; pin_in = '0;
      sw_standby = 1'b0; hw_standby = 1'b0; standby_oe = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;

      // R1 reset state
      check("R1", "pin_oe", {4'h0, pin_oe}, 8'h00);
      check("R1", "pin_pu", {4'h0, pin_pu}, 8'h00);
      bus_read(A_DAT, 8'h00, "R1");
      bus_read(A_PUL, 8'h00, "R1");
      bus_read(A_ODC, 8'h00, "R1");

      // R2 register write/read back, high bits zero
      bus_write(A_DAT, 8'hA5); bus_read(A_DAT, 8'h05, "R2");
      bus_write(A_PUL, 8'h3C); bus_read(A_PUL, 8'h0C, "R2");
      bus_write(A_ODC, 8'h81); bus_read(A_ODC, 8'h01, "R2");
      bus_write(A_ODC, 8'h00); bus_write(A_PUL, 8'h00);

      // R3 direction reads fixed, upper write bits without effect
      bus_write(A_DIR, 8'h0F); bus_read(A_DIR, 8'hFF, "R3");
      bus_write(A_DIR, 8'hF0); #1;
      check("R3", "pin_oe", {4'h0, pin_oe}, 8'h00);

      // R4 pin sample, write ignored
      pin_in = 4'b1001;
      bus_write(A_PIN, 8'hFF); bus_read(A_PIN, 8'h09, "R4");
      bus_read(A_DAT, 8'h05, "R4");

      // R7 general-purpose output from data latch
      bus_write(A_DIR, 8'h05); #1;
      check("R7", "pin_oe", {4'h0, pin_oe}, 8'h05);
      check("R7", "pin_out", {4'h0, pin_out}, 8'h05);

      // R6 mixed mode
      @(negedge clk); op_mode = 3'd6; int_addr = 4'b1111; #1;
      check("R6", "pin_oe", {4'h0, pin_oe}, 8'h05);
      check("R6", "pin_out", {4'h0, pin_out}, 8'h05);

      // R5 forced address modes
      @(negedge clk); op_mode = 3'd4; int_addr = 4'b1010; #1;
      check("R5", "pin_oe", {4'h0, pin_oe}, 8'h0F);
      check("R5", "pin_out", {4'h0, pin_out}, 8'h0A);
      @(negedge clk); op_mode = 3'd5; #1;
      check("R5", "pin_oe", {4'h0, pin_oe}, 8'h0F);

      // R9 open drain on address pins
      bus_write(A_ODC, 8'h03); #1;
      check("R9", "pin_oe", {4'h0, pin_oe}, 8'h0D);
      check("R9", "pin_out", {4'h0, pin_out}, 8'h08);
      bus_write(A_ODC, 8'h00);

      // R8 pull-ups only on inputs
      @(negedge clk); op_mode = 3'd7;
      bus_write(A_PUL, 8'h0F); #1;
      check("R8", "pin_pu", {4'h0, pin_pu}, 8'h0A);

      // R10 software standby hold and release
      @(negedge clk); op_mode = 3'd4; int_addr = 4'b0110; standby_oe = 1'b1;
      @(negedge clk); sw_standby = 1'b1; int_addr = 4'b1001; #1;
      check("R10", "pin_out", {4'h0, pin_out}, 8'h06);
      check("R10", "pin_oe", {4'h0, pin_oe}, 8'h0F);
      @(negedge clk); int_addr = 4'b0000; #1;
      check("R10", "pin_out", {4'h0, pin_out}, 8'h06);
      standby_oe = 1'b0; #1;
      check("R10", "pin_oe", {4'h0, pin_oe}, 8'h00);
      @(negedge clk); op_mode = 3'd7; #1;
      check("R10", "pin_oe", {4'h0, pin_oe}, 8'h05);

      // R11 software standby keeps direction, hardware standby clears it
      repeat (3) @(negedge clk);
      sw_standby = 1'b0; op_mode = 3'd6; #1;
      check("R11", "pin_oe", {4'h0, pin_oe}, 8'h05);
      @(negedge clk); hw_standby = 1'b1; bus_addr = A_DIR; bus_wdata = 8'h0F; bus_wr = 1'b1;
      @(negedge clk); hw_standby = 1'b0; bus_wr = 1'b0; #1;
      check("R11", "pin_oe", {4'h0, pin_oe}, 8'h00);

      // Random mix checked against the model
      for (int k = 0; k < 4000; k++) begin
         string tag;
         @(negedge clk);
         op_mode    = 3'($urandom);
         int_addr   = W'($urandom);
         pin_in     = W'($urandom);
         sw_standby = ($urandom % 4) == 0;
         standby_oe = 1'($urandom);
         hw_standby = ($urandom % 20) == 0;
         bus_wr     = 1'($urandom);
         bus_wdata  = 8'($urandom);
         case ($urandom % 6)
            0: bus_addr = A_DIR;
            1: bus_addr = A_DAT;
            2: bus_addr = A_PIN;
            3: bus_addr = A_PUL;
            4: bus_addr = A_ODC;
            default: bus_addr = 16'($urandom);
         endcase
         #1;
         if (sw_standby) tag = "R10";
         else if (op_mode == 3'd4 || op_mode == 3'd5) tag = "R5";
         else if (op_mode == 3'd6) tag = "R6";
         else tag = "R7";
         check_pins(tag);
      end
      @(negedge clk);
      bus_wr = 1'b0; sw_standby = 1'b0; hw_standby = 1'b0;
      finish_run();
   end

endmodule